// File: doc/BRIEF.md
# Decode-Stage Branch Redirect Checker

This block sits at the output of an instruction decode stage and compares each instruction that decode forwards against the prediction made at fetch. A group of up to `LANES` instructions from one hardware thread arrives each cycle. For each lane the block receives the PC, the predicted next PC, a predicted-taken bit, control-type flags (control, direct, unconditional, conditional delay slot), the branch target already computed from the opcode, and a sequence number. Only direct unconditional transfers can be resolved this early. When such a transfer's computed target disagrees with the predicted next PC, the block issues a squash record to fetch. The record carries the offending sequence number, the redirect PC, the PC one instruction after it, and a taken indication. In the same cycle it marks the younger in-flight instructions of that thread as squashed.

A build-time parameter selects a delay-slot variant. In that variant a mispredicted branch is normally forwarded together with the instruction after it, and the squash waits until that slot instruction has gone out. The squash point is then the branch sequence number plus one. The pending squash is kept per thread, so it can wait across cycles until that thread's next group arrives. Flushing of the in-flight list then stops at the first surviving entry of the thread. All outputs are registered and appear one cycle after the inputs that cause them.

Top module: `decode_redirect_check`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `fwdMask`, `sqValid`, `ctrlMispred`, `killMask`, `resolvedCount` and `mispredCount` are all zero.
- R2: A forwarded lane counts as resolved only when both `laneIsDirect` and `laneIsUncond` are 1. It counts as mispredicted when, in addition, `laneTarget` differs from `laneNextPred`. `resolvedCount` and `mispredCount` grow by those numbers one cycle later and wrap at 2^CNT_W.
- R3: Without delay slots, a mispredicted lane causes a squash record one cycle later. In that record `sqValid`=1, `sqSeq` is the lane's sequence number, `sqTid` is `grpTid`, `sqNextPc` is the lane's target and `sqFollowPc` is the target plus 4.
- R4: `sqTaken` is 1 exactly when the redirect target differs from the branch's own PC plus 4.
- R5: A forwarded lane that is checked, with `laneTakenPred`=1 and `laneIsCtrl`=0, raises `ctrlMispred` for one cycle. This does not by itself cause a squash.
- R6: Lanes are visited from index 0 upward, and only lanes with `grpValid` set are forwarded. The lane that triggers a squash is forwarded. No later lane of the same group is forwarded.
- R7: Without delay slots, a squash sets `killMask[j]` for every valid in-flight entry of the same thread whose sequence number is strictly greater than `sqSeq`. Entries of other threads, and entries with equal or smaller numbers, are left alone.
- R8: With delay slots, a mispredicted lane that has both `laneTakenPred`=1 and `laneCondSlot`=1 squashes immediately, at its own sequence number.
- R9: With delay slots, any other mispredicted lane is forwarded and does not squash yet. If a later valid lane exists in the same group, that lane (the slot) is forwarded without being checked. The squash then issues with `sqSeq` equal to the branch number plus 1, and no further lanes are forwarded.
- R10: With delay slots, a deferral that reaches the end of its group is held for that thread. Groups from other threads are processed normally in the meantime. The next group of the same thread forwards its first valid lane unchecked, issues the held squash at branch number plus 1, and clears the hold.
- R11: With delay slots, the kill scan walks the in-flight entries from index 0 upward and skips entries of other threads. It marks same-thread entries numbered above the squash point until the first same-thread entry at or below that point. That entry, and every entry after it, is kept.
- R12: `sqValid` is high only in cycles that follow a triggering input cycle. Without a new trigger, it drops the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grpValid | input | LANES | Lane occupied this cycle |
| grpTid | input | TID_W | Thread owning the whole group |
| lanePc | input | LANES x PC_W | PC of each lane |
| laneNextPred | input | LANES x PC_W | Predicted next PC from fetch |
| laneTakenPred | input | LANES | Fetch predicted the lane as taken |
| laneIsCtrl | input | LANES | Lane is a control transfer |
| laneIsDirect | input | LANES | Lane is a direct (PC-relative) transfer |
| laneIsUncond | input | LANES | Lane is an unconditional transfer |
| laneCondSlot | input | LANES | Lane carries a conditional delay slot |
| laneTarget | input | LANES x PC_W | Target computed from the opcode |
| laneSeq | input | LANES x SEQ_W | Sequence number of each lane |
| flValid | input | INFLIGHT | In-flight entry occupied |
| flTid | input | INFLIGHT x TID_W | Thread of each in-flight entry |
| flSeq | input | INFLIGHT x SEQ_W | Sequence number of each in-flight entry |
| fwdMask | output | LANES | Lanes forwarded in the previous cycle |
| sqValid | output | 1 | Squash record valid |
| sqTid | output | TID_W | Thread being squashed |
| sqSeq | output | SEQ_W | Squash point sequence number |
| sqNextPc | output | PC_W | Redirect PC |
| sqFollowPc | output | PC_W | Redirect PC plus one instruction |
| sqTaken | output | 1 | Resolved branch left the sequential path |
| ctrlMispred | output | 1 | Non-control lane was predicted taken |
| killMask | output | INFLIGHT | In-flight entries marked squashed |
| resolvedCount | output | CNT_W | Running count of resolved branches |
| mispredCount | output | CNT_W | Running count of mispredicted branches |

## Verification
The hardest situation to reach is a delay-slot deferral that ends its group. The held squash must survive an intervening group from the other thread and fire only on the next group of its own thread. A directed sequence builds that case by placing the mispredicted branch in the last lane and then sending one group from each thread in turn. The stop-at-first-survivor kill scan is driven with in-flight sequence numbers that are deliberately out of order. This makes the two variants' kill masks visibly diverge. Long random runs use small sequence-number ranges, so that equal, older and younger entries mix in every squash.

// File: rtl/decode_redirect_pkg.sv
package decode_redirect_pkg;

  localparam int unsigned INSN_BYTES = 4;

  // Strobes issued by the lane-walk control toward the datapath.
  typedef struct packed {
    logic fire;         // a squash record is produced this cycle
    logic fromPending;  // record comes from the held per-thread deferral
    logic plusOne;      // squash point is branch number + 1
    logic capture;      // store the deferred branch for this thread
    logic ctrlFlag;     // a non-control lane was predicted taken
  } redirect_strobe_t;

endpackage

// File: rtl/decode_redirect_ctrl.sv
module decode_redirect_ctrl
  import decode_redirect_pkg::*;
#(
  parameter int unsigned LANES      = 4,
  parameter int unsigned THREADS    = 2,
  parameter bit          DELAY_SLOT = 1'b0,
  localparam int unsigned LANE_W    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned CINC_W    = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      grpValid,
  input  logic [TID_W-1:0]      grpTid,
  input  logic [LANES-1:0]      laneTakenPred,
  input  logic [LANES-1:0]      laneIsCtrl,
  input  logic [LANES-1:0]      laneIsDirect,
  input  logic [LANES-1:0]      laneIsUncond,
  input  logic [LANES-1:0]      laneCondSlot,
  input  logic [LANES-1:0]      laneMiss,
  output redirect_strobe_t      strobe,
  output logic [LANE_W-1:0]     srcLane,
  output logic [LANE_W-1:0]     capLane,
  output logic [LANES-1:0]      fwdNext,
  output logic [CINC_W-1:0]     resolvedInc,
  output logic [CINC_W-1:0]     mispredInc
);

  logic [THREADS-1:0] pendValid;
  logic               pendHere;
  logic               halt;
  logic               deferHit;

  assign pendHere = pendValid[grpTid];

  // Walk lanes in order; stop after the lane that fires a squash.
  always_comb begin
    strobe      = '0;
    srcLane     = '0;
    capLane     = '0;
    fwdNext     = '0;
    resolvedInc = '0;
    mispredInc  = '0;
    halt        = 1'b0;
    deferHit    = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (grpValid[i] && !halt) begin
        fwdNext[i] = 1'b1;
        if (pendHere) begin
          strobe.fire        = 1'b1;
          strobe.fromPending = 1'b1;
          strobe.plusOne     = 1'b1;
          halt               = 1'b1;
        end else if (deferHit) begin
          strobe.fire    = 1'b1;
          strobe.plusOne = 1'b1;
          srcLane        = capLane;
          halt           = 1'b1;
        end else begin
          if (laneTakenPred[i] && !laneIsCtrl[i]) strobe.ctrlFlag = 1'b1;
          if (laneIsDirect[i] && laneIsUncond[i]) begin
            resolvedInc = resolvedInc + CINC_W'(1);
            if (laneMiss[i]) begin
              mispredInc = mispredInc + CINC_W'(1);
              if (!DELAY_SLOT || (laneTakenPred[i] && laneCondSlot[i])) begin
                strobe.fire = 1'b1;
                srcLane     = LANE_W'(i);
                halt        = 1'b1;
              end else begin
                deferHit = 1'b1;
                capLane  = LANE_W'(i);
              end
            end
          end
        end
      end
    end
    strobe.capture = deferHit && !strobe.fire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendValid <= '0;
    end else if (strobe.capture) begin
      pendValid[grpTid] <= 1'b1;
    end else if (strobe.fire && strobe.fromPending) begin
      pendValid[grpTid] <= 1'b0;
    end
  end

  // A held deferral must be issued by the first group of its thread.
  assert_pend_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grpValid) && pendValid[grpTid]) |-> (strobe.fire && strobe.fromPending));

  // After a held squash is issued the hold is gone on the next cycle.
  assert_pend_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fire && strobe.fromPending) |=> !pendValid[$past(grpTid)]);

  // Deferral state exists only in the delay-slot variant.
  assert_pend_only_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pendValid != '0) |-> DELAY_SLOT);

endmodule

// File: rtl/decode_redirect_dp.sv
module decode_redirect_dp
  import decode_redirect_pkg::*;
#(
  parameter int unsigned LANES      = 4,
  parameter int unsigned THREADS    = 2,
  parameter int unsigned INFLIGHT   = 8,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned SEQ_W      = 16,
  parameter int unsigned CNT_W      = 16,
  parameter bit          DELAY_SLOT = 1'b0,
  localparam int unsigned LANE_W    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned CINC_W    = $clog2(LANES + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  redirect_strobe_t                  strobe,
  input  logic [LANE_W-1:0]                 srcLane,
  input  logic [LANE_W-1:0]                 capLane,
  input  logic [LANES-1:0]                  fwdNext,
  input  logic [CINC_W-1:0]                 resolvedInc,
  input  logic [CINC_W-1:0]                 mispredInc,
  input  logic [TID_W-1:0]                  grpTid,
  input  logic [LANES-1:0][PC_W-1:0]        lanePc,
  input  logic [LANES-1:0][PC_W-1:0]        laneNextPred,
  input  logic [LANES-1:0][PC_W-1:0]        laneTarget,
  input  logic [LANES-1:0][SEQ_W-1:0]       laneSeq,
  input  logic [INFLIGHT-1:0]               flValid,
  input  logic [INFLIGHT-1:0][TID_W-1:0]    flTid,
  input  logic [INFLIGHT-1:0][SEQ_W-1:0]    flSeq,
  output logic [LANES-1:0]                  laneMiss,
  output logic [LANES-1:0]                  fwdMask,
  output logic                              sqValid,
  output logic [TID_W-1:0]                  sqTid,
  output logic [SEQ_W-1:0]                  sqSeq,
  output logic [PC_W-1:0]                   sqNextPc,
  output logic [PC_W-1:0]                   sqFollowPc,
  output logic                              sqTaken,
  output logic                              ctrlMispred,
  output logic [INFLIGHT-1:0]               killMask,
  output logic [CNT_W-1:0]                  resolvedCount,
  output logic [CNT_W-1:0]                  mispredCount
);

  logic [SEQ_W-1:0] pendSeq [THREADS];
  logic [PC_W-1:0]  pendPc  [THREADS];
  logic [PC_W-1:0]  pendTgt [THREADS];

  logic [SEQ_W-1:0]    selSeq, pointSeq;
  logic [PC_W-1:0]     selPc, selTgt;
  logic [INFLIGHT-1:0] killNext;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_miss
      assign laneMiss[g] = laneTarget[g] != laneNextPred[g];
    end
  endgenerate

  always_comb begin
    if (strobe.fromPending) begin
      selSeq = pendSeq[grpTid];
      selPc  = pendPc[grpTid];
      selTgt = pendTgt[grpTid];
    end else begin
      selSeq = laneSeq[srcLane];
      selPc  = lanePc[srcLane];
      selTgt = laneTarget[srcLane];
    end
    pointSeq = selSeq + (strobe.plusOne ? SEQ_W'(1) : SEQ_W'(0));
  end

  generate
    if (DELAY_SLOT) begin : g_kill_stop
      // Flush from the front; the first same-thread survivor ends the flush.
      always_comb begin
        logic stopped;
        stopped  = 1'b0;
        killNext = '0;
        for (int j = 0; j < INFLIGHT; j++) begin
          if (strobe.fire && flValid[j] && flTid[j] == grpTid) begin
            if (!stopped && flSeq[j] > pointSeq) killNext[j] = 1'b1;
            else                                 stopped     = 1'b1;
          end
        end
      end
    end else begin : g_kill_all
      always_comb begin
        killNext = '0;
        for (int j = 0; j < INFLIGHT; j++) begin
          killNext[j] = strobe.fire && flValid[j] && flTid[j] == grpTid
                        && flSeq[j] > pointSeq;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++) begin
        pendSeq[t] <= '0;
        pendPc[t]  <= '0;
        pendTgt[t] <= '0;
      end
    end else if (strobe.capture) begin
      pendSeq[grpTid] <= laneSeq[capLane];
      pendPc[grpTid]  <= lanePc[capLane];
      pendTgt[grpTid] <= laneTarget[capLane];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwdMask       <= '0;
      sqValid       <= 1'b0;
      sqTid         <= '0;
      sqSeq         <= '0;
      sqNextPc      <= '0;
      sqFollowPc    <= '0;
      sqTaken       <= 1'b0;
      ctrlMispred   <= 1'b0;
      killMask      <= '0;
      resolvedCount <= '0;
      mispredCount  <= '0;
    end else begin
      fwdMask       <= fwdNext;
      sqValid       <= strobe.fire;
      ctrlMispred   <= strobe.ctrlFlag;
      killMask      <= killNext;
      resolvedCount <= resolvedCount + CNT_W'(resolvedInc);
      mispredCount  <= mispredCount + CNT_W'(mispredInc);
      if (strobe.fire) begin
        sqTid      <= grpTid;
        sqSeq      <= pointSeq;
        sqNextPc   <= selTgt;
        sqFollowPc <= selTgt + PC_W'(INSN_BYTES);
        sqTaken    <= selTgt != selPc + PC_W'(INSN_BYTES);
      end
    end
  end

  // Kill marks only accompany a squash record.
  assert_kill_with_squash_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|killMask) |-> sqValid);

  // Every counted misprediction is also a counted resolution.
  assert_mispred_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mispredCount) |-> !$stable(resolvedCount));

  // A squash record is produced only after a strobe asking for one.
  assert_squash_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.fire |=> !sqValid);

endmodule

// File: rtl/decode_redirect_check.sv
module decode_redirect_check
  import decode_redirect_pkg::*;
#(
  parameter int unsigned LANES      = 4,
  parameter int unsigned THREADS    = 2,
  parameter int unsigned INFLIGHT   = 8,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned SEQ_W      = 16,
  parameter int unsigned CNT_W      = 16,
  parameter bit          DELAY_SLOT = 1'b0,
  localparam int unsigned LANE_W    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned CINC_W    = $clog2(LANES + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LANES-1:0]               grpValid,
  input  logic [TID_W-1:0]               grpTid,
  input  logic [LANES-1:0][PC_W-1:0]     lanePc,
  input  logic [LANES-1:0][PC_W-1:0]     laneNextPred,
  input  logic [LANES-1:0]               laneTakenPred,
  input  logic [LANES-1:0]               laneIsCtrl,
  input  logic [LANES-1:0]               laneIsDirect,
  input  logic [LANES-1:0]               laneIsUncond,
  input  logic [LANES-1:0]               laneCondSlot,
  input  logic [LANES-1:0][PC_W-1:0]     laneTarget,
  input  logic [LANES-1:0][SEQ_W-1:0]    laneSeq,
  input  logic [INFLIGHT-1:0]            flValid,
  input  logic [INFLIGHT-1:0][TID_W-1:0] flTid,
  input  logic [INFLIGHT-1:0][SEQ_W-1:0] flSeq,
  output logic [LANES-1:0]               fwdMask,
  output logic                           sqValid,
  output logic [TID_W-1:0]               sqTid,
  output logic [SEQ_W-1:0]               sqSeq,
  output logic [PC_W-1:0]                sqNextPc,
  output logic [PC_W-1:0]                sqFollowPc,
  output logic                           sqTaken,
  output logic                           ctrlMispred,
  output logic [INFLIGHT-1:0]            killMask,
  output logic [CNT_W-1:0]               resolvedCount,
  output logic [CNT_W-1:0]               mispredCount
);

  redirect_strobe_t    strobe;
  logic [LANE_W-1:0]   srcLane, capLane;
  logic [LANES-1:0]    fwdNext, laneMiss;
  logic [CINC_W-1:0]   resolvedInc, mispredInc;

  decode_redirect_ctrl #(
    .LANES(LANES), .THREADS(THREADS), .DELAY_SLOT(DELAY_SLOT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .grpValid(grpValid), .grpTid(grpTid),
    .laneTakenPred(laneTakenPred), .laneIsCtrl(laneIsCtrl),
    .laneIsDirect(laneIsDirect), .laneIsUncond(laneIsUncond),
    .laneCondSlot(laneCondSlot), .laneMiss(laneMiss),
    .strobe(strobe), .srcLane(srcLane), .capLane(capLane),
    .fwdNext(fwdNext), .resolvedInc(resolvedInc), .mispredInc(mispredInc)
  );

  decode_redirect_dp #(
    .LANES(LANES), .THREADS(THREADS), .INFLIGHT(INFLIGHT), .PC_W(PC_W),
    .SEQ_W(SEQ_W), .CNT_W(CNT_W), .DELAY_SLOT(DELAY_SLOT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .strobe(strobe), .srcLane(srcLane), .capLane(capLane),
    .fwdNext(fwdNext), .resolvedInc(resolvedInc), .mispredInc(mispredInc),
    .grpTid(grpTid), .lanePc(lanePc), .laneNextPred(laneNextPred),
    .laneTarget(laneTarget), .laneSeq(laneSeq),
    .flValid(flValid), .flTid(flTid), .flSeq(flSeq),
    .laneMiss(laneMiss), .fwdMask(fwdMask),
    .sqValid(sqValid), .sqTid(sqTid), .sqSeq(sqSeq),
    .sqNextPc(sqNextPc), .sqFollowPc(sqFollowPc), .sqTaken(sqTaken),
    .ctrlMispred(ctrlMispred), .killMask(killMask),
    .resolvedCount(resolvedCount), .mispredCount(mispredCount)
  );

endmodule

// File: tb/decode_redirect_check_bench.sv
`timescale 1ns/1ps
module decode_redirect_check_bench;

  localparam int L = 4;
  localparam int F = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [L-1:0]         gV;
  logic                 gT;
  logic [L-1:0][31:0]   pc, pn, tg;
  logic [L-1:0][15:0]   sq;
  logic [L-1:0]         pt, ic, id, iu, cs;
  logic [F-1:0]         fV;
  logic [F-1:0][0:0]    fT;
  logic [F-1:0][15:0]   fS;

  logic [L-1:0] oFwd [2];
  logic         oSqV [2];
  logic         oTid [2];
  logic [15:0]  oSeq [2];
  logic [31:0]  oNext [2];
  logic [31:0]  oFol [2];
  logic         oTaken [2];
  logic         oCtrl [2];
  logic [F-1:0] oKill [2];
  logic [15:0]  oRes [2];
  logic [15:0]  oMis [2];

  decode_redirect_check #(.LANES(L), .THREADS(2), .INFLIGHT(F), .DELAY_SLOT(1'b0)) u_decode_redirect_check (
    .clk(clk), .rst_n(rst_n), .grpValid(gV), .grpTid(gT), .lanePc(pc), .laneNextPred(pn),
    .laneTakenPred(pt), .laneIsCtrl(ic), .laneIsDirect(id), .laneIsUncond(iu), .laneCondSlot(cs),
    .laneTarget(tg), .laneSeq(sq), .flValid(fV), .flTid(fT), .flSeq(fS),
    .fwdMask(oFwd[0]), .sqValid(oSqV[0]), .sqTid(oTid[0]), .sqSeq(oSeq[0]), .sqNextPc(oNext[0]),
    .sqFollowPc(oFol[0]), .sqTaken(oTaken[0]), .ctrlMispred(oCtrl[0]), .killMask(oKill[0]),
    .resolvedCount(oRes[0]), .mispredCount(oMis[0]));

  decode_redirect_check #(.LANES(L), .THREADS(2), .INFLIGHT(F), .DELAY_SLOT(1'b1)) u_decode_redirect_check_slot (
    .clk(clk), .rst_n(rst_n), .grpValid(gV), .grpTid(gT), .lanePc(pc), .laneNextPred(pn),
    .laneTakenPred(pt), .laneIsCtrl(ic), .laneIsDirect(id), .laneIsUncond(iu), .laneCondSlot(cs),
    .laneTarget(tg), .laneSeq(sq), .flValid(fV), .flTid(fT), .flSeq(fS),
    .fwdMask(oFwd[1]), .sqValid(oSqV[1]), .sqTid(oTid[1]), .sqSeq(oSeq[1]), .sqNextPc(oNext[1]),
    .sqFollowPc(oFol[1]), .sqTaken(oTaken[1]), .ctrlMispred(oCtrl[1]), .killMask(oKill[1]),
    .resolvedCount(oRes[1]), .mispredCount(oMis[1]));

  int checks = 0;
  int errors = 0;

  // Reference state, per variant (0 = plain, 1 = delay slot) and per thread.
  bit          mPendV [2][2];
  logic [15:0] mPendSeq [2][2];
  logic [31:0] mPendPc [2][2];
  logic [31:0] mPendTgt [2][2];

  logic [L-1:0] eFwd [2];
  bit           eSqV [2];
  logic [15:0]  eSeq [2];
  logic [31:0]  eNext [2];
  logic         eTid [2];
  bit           eTaken [2];
  bit           eCtrl [2];
  logic [F-1:0] eKill [2];
  logic [15:0]  eRes [2];
  logic [15:0]  eMis [2];
  string        eTag [2];

  task automatic chk(string tag, string what, int m, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s variant%0d actual %0h expected %0h at %0t", tag, what, m, act, exp, $time);
    end
  endtask

  task automatic clearIn();
    gV = '0; gT = 1'b0; pc = '0; pn = '0; tg = '0; sq = '0;
    pt = '0; ic = '0; id = '0; iu = '0; cs = '0;
    fV = '0; fT = '0; fS = '0;
  endtask

  task automatic setBr(int i, logic [31:0] p, logic [31:0] n, logic [31:0] t,
                       logic [15:0] s, bit tk, bit slot);
    gV[i] = 1'b1; pc[i] = p; pn[i] = n; tg[i] = t; sq[i] = s;
    pt[i] = tk; ic[i] = 1'b1; id[i] = 1'b1; iu[i] = 1'b1; cs[i] = slot;
  endtask

  task automatic setPlain(int i, logic [31:0] p, logic [15:0] s);
    gV[i] = 1'b1; pc[i] = p; pn[i] = p + 4; tg[i] = p + 4; sq[i] = s;
    pt[i] = 1'b0; ic[i] = 1'b0; id[i] = 1'b0; iu[i] = 1'b0; cs[i] = 1'b0;
  endtask

  task automatic runModel(int m);
    bit stop, fire, ctrl;
    int defer, res, mis, t;
    logic [15:0] pSeq;
    logic [31:0] pPc, pTgt;
    bit stopped;
    stop = 0; fire = 0; ctrl = 0; defer = -1; res = 0; mis = 0;
    pSeq = '0; pPc = '0; pTgt = '0;
    t = int'(gT);
    eFwd[m] = '0; eKill[m] = '0; eTag[m] = "R12";
    for (int i = 0; i < L; i++) begin
      if (gV[i] && !stop) begin
        eFwd[m][i] = 1'b1;
        if (mPendV[m][t]) begin
          fire = 1; stop = 1; eTag[m] = "R10";
          pSeq = mPendSeq[m][t] + 16'd1; pPc = mPendPc[m][t]; pTgt = mPendTgt[m][t];
          mPendV[m][t] = 0;
        end else if (defer >= 0) begin
          fire = 1; stop = 1; eTag[m] = "R9";
          pSeq = sq[defer] + 16'd1; pPc = pc[defer]; pTgt = tg[defer];
        end else begin
          if (pt[i] && !ic[i]) ctrl = 1;
          if (id[i] && iu[i]) begin
            res++;
            if (tg[i] != pn[i]) begin
              mis++;
              if (m == 0 || (pt[i] && cs[i])) begin
                fire = 1; stop = 1; eTag[m] = (m == 0) ? "R3" : "R8";
                pSeq = sq[i]; pPc = pc[i]; pTgt = tg[i];
              end else begin
                defer = i;
              end
            end
          end
        end
      end
    end
    if (defer >= 0 && !fire) begin
      mPendV[m][t] = 1; mPendSeq[m][t] = sq[defer];
      mPendPc[m][t] = pc[defer]; mPendTgt[m][t] = tg[defer];
    end
    stopped = 0;
    if (fire) begin
      for (int j = 0; j < F; j++) begin
        if (fV[j] && int'(fT[j]) == t) begin
          if (m == 0) eKill[m][j] = fS[j] > pSeq;
          else if (!stopped && fS[j] > pSeq) eKill[m][j] = 1'b1;
          else stopped = 1;
        end
      end
    end
    eSqV[m] = fire; eCtrl[m] = ctrl;
    if (fire) begin
      eSeq[m] = pSeq; eNext[m] = pTgt; eTid[m] = gT; eTaken[m] = (pTgt != pPc + 32'd4);
    end
    eRes[m] = eRes[m] + 16'(res);
    eMis[m] = eMis[m] + 16'(mis);
  endtask

  task automatic compareAll();
    for (int m = 0; m < 2; m++) begin
      chk("R6", "fwdMask", m, 32'(oFwd[m]), 32'(eFwd[m]));
      chk(eTag[m], "sqValid", m, 32'(oSqV[m]), 32'(eSqV[m]));
      if (eSqV[m]) begin
        chk(eTag[m], "sqSeq", m, 32'(oSeq[m]), 32'(eSeq[m]));
        chk(eTag[m], "sqTid", m, 32'(oTid[m]), 32'(eTid[m]));
        chk(eTag[m], "sqNextPc", m, oNext[m], eNext[m]);
        chk(eTag[m], "sqFollowPc", m, oFol[m], eNext[m] + 32'd4);
        chk("R4", "sqTaken", m, 32'(oTaken[m]), 32'(eTaken[m]));
      end
      chk("R5", "ctrlMispred", m, 32'(oCtrl[m]), 32'(eCtrl[m]));
      chk((m == 0) ? "R7" : "R11", "killMask", m, 32'(oKill[m]), 32'(eKill[m]));
      chk("R2", "resolvedCount", m, 32'(oRes[m]), 32'(eRes[m]));
      chk("R2", "mispredCount", m, 32'(oMis[m]), 32'(eMis[m]));
    end
  endtask

  task automatic step();
    runModel(0);
    runModel(1);
    @(negedge clk);
    compareAll();
  endtask

  task automatic randStim();
    gV = L'($urandom); gT = 1'($urandom);
    for (int i = 0; i < L; i++) begin
      pc[i] = $urandom & 32'hFFFF_FFFC;
      pt[i] = 1'($urandom);
      pn[i] = pt[i] ? ($urandom & 32'hFFFF_FFFC) : pc[i] + 4;
      ic[i] = ($urandom % 4) != 0;
      id[i] = ($urandom % 10) < 7;
      iu[i] = ($urandom % 10) < 7;
      cs[i] = 1'($urandom);
      case ($urandom % 3)
        0: tg[i] = pn[i];
        1: tg[i] = pc[i] + 4;
        default: tg[i] = $urandom & 32'hFFFF_FFFC;
      endcase
      sq[i] = 16'($urandom % 32);
    end
    for (int j = 0; j < F; j++) begin
      fV[j] = 1'($urandom); fT[j] = 1'($urandom); fS[j] = 16'($urandom % 32);
    end
  endtask

  task automatic flights(logic [15:0] a, logic [15:0] b, logic [15:0] c, logic [15:0] d);
    fV = 8'h0F; fT = '0;
    fS[0] = a; fS[1] = b; fS[2] = c; fS[3] = d;
    fV[4] = 1'b1; fT[4] = 1'b1; fS[4] = 16'd60;
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      eRes[m] = '0; eMis[m] = '0;
      for (int t = 0; t < 2; t++) mPendV[m][t] = 0;
    end
    clearIn();
    repeat (3) @(negedge clk);
    // R1: state during reset
    for (int m = 0; m < 2; m++) begin
      chk("R1", "sqValid", m, 32'(oSqV[m]), 32'd0);
      chk("R1", "fwdMask", m, 32'(oFwd[m]), 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk("R1", "killMask", m, 32'(oKill[m]), 32'd0);
      chk("R1", "ctrlMispred", m, 32'(oCtrl[m]), 32'd0);
      chk("R1", "resolvedCount", m, 32'(oRes[m]), 32'd0);
      chk("R1", "mispredCount", m, 32'(oMis[m]), 32'd0);
    end

    // R3 R6 R7 R9: mispredict in lane 1, younger/older/equal in-flight mix
    clearIn();
    setPlain(0, 32'h40, 16'd10);
    setBr(1, 32'h44, 32'h100, 32'h200, 16'd11, 1'b1, 1'b0);
    setPlain(2, 32'h48, 16'd12);
    setPlain(3, 32'h4C, 16'd13);
    flights(16'd14, 16'd11, 16'd9, 16'd20);
    step();
    // R12: idle cycle drops the record
    clearIn(); step();

    // R8: predicted taken with conditional slot squashes at own number
    setBr(0, 32'h80, 32'h90, 32'h84, 16'd20, 1'b1, 1'b1);
    setPlain(1, 32'h84, 16'd21);
    flights(16'd22, 16'd20, 16'd25, 16'd19);
    step();

    // R5: non-control predicted taken
    clearIn();
    setPlain(0, 32'hA0, 16'd3); pt[0] = 1'b1; pn[0] = 32'h300;
    step();

    // R10 R11: deferral at end of group, other thread between, then release
    clearIn();
    setPlain(0, 32'hC0, 16'd5);
    setBr(3, 32'hCC, 32'hD0, 32'h400, 16'd8, 1'b0, 1'b0);
    step();
    clearIn(); gT = 1'b1;
    setPlain(0, 32'h500, 16'd40);
    setBr(1, 32'h504, 32'h508, 32'h600, 16'd41, 1'b0, 1'b0);
    setPlain(2, 32'h508, 16'd42);
    step();
    clearIn(); gT = 1'b0;
    setPlain(1, 32'hD0, 16'd9);
    setPlain(2, 32'hD4, 16'd10);
    flights(16'd12, 16'd7, 16'd15, 16'd11);
    step();
    clearIn(); step();

    for (int n = 0; n < 4000; n++) begin
      randStim();
      step();
    end
    clearIn(); step();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule